// File: doc/BRIEF.md
# Mode-Configurable Direct-Mapped Read Cache

This block is a 2-Kbyte direct-mapped read cache shared by instruction fetches and operand reads. It holds 128 lines of 16 bytes. The tags and the 512-word data store are read in parallel, so a hit returns its word in the same cycle the request is presented. A 2-bit mode input chooses how the store is used. It can cache instruction fetches only, cache operand reads only, or split the store into two 64-line halves, one for each access type. In split mode the top bit of the line index comes from the access type rather than from the address.

On a miss, the block asks memory for the whole 16-byte line. Memory returns it as four 32-bit beats in ascending word order, and the beats are gathered in a line buffer. The requested word goes back to the core in the cycle its beat arrives. The full line is written into the store in one cycle after the last beat. An access of the type the current mode does not cache is still fetched from memory the same way, but it is never written into the store.

Changing the mode, or pulsing the invalidate input, clears every valid bit by walking the 128 lines, one per cycle. Requests are stalled while the walk runs. A request is taken when `req_valid` is high and `req_stall` is low. The core holds the request until it is taken and receives exactly one `rsp_valid` for it.

Top module: `cfg_split_cache`

## Requirements
- R1: `cfg_mode` 2'b00 caches instruction fetches only, 2'b01 caches operand reads only, and 2'b10 or 2'b11 selects split mode. `req_is_data`=1 marks an operand read and 0 marks an instruction fetch.
- R2: A taken request (`req_valid` high while `req_stall` is low) that hits raises `rsp_valid` with the addressed word in that same cycle.
- R3: In the two non-split modes the line index is `req_addr[10:4]`, so all 128 lines of any aligned 2-Kbyte region can be resident at once.
- R4: In split mode the line index is {`req_is_data`, `req_addr[9:4]`}. Instruction and operand lines never evict each other, and two addresses of the same type 1 Kbyte apart share a line.
- R5: A hit requires the stored upper address bits `req_addr[31:10]` to match, so an address 2 Kbytes away from a resident one misses and replaces that line.
- R6: A miss raises `mem_req_valid` with `mem_req_addr` = {`req_addr[31:4]`, 4'b0}. Both are held unchanged until `mem_req_ready` is sampled high.
- R7: After the handshake, the first four cycles with `mem_beat_valid` high carry words 0 to 3 of the line. `rsp_valid` rises, with that beat's data on `rsp_data`, only in the cycle of the beat whose number equals `req_addr[3:2]`.
- R8: After the fourth beat, a cacheable line takes one further stalled cycle to be written into the store. A bypassed line returns to idle at once.
- R9: In a non-split mode, an access of the uncached type is fetched as in R6 and R7 but is never stored. Repeating it misses again, and resident lines stay unchanged.
- R10: A change of `cfg_mode`, or `inval` high for a cycle, holds `req_stall` high for exactly 129 cycles starting in the next cycle (one start cycle, then 128 clear cycles). Afterwards every line misses.
- R11: Reset clears every valid bit and leaves `req_stall`, `rsp_valid` and `mem_req_valid` low. The mode present during reset is taken as the current mode.
- R12: While `req_stall` is high, `req_valid` is ignored. Beats that arrive outside a line fill are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Arrangement select (see R1) |
| inval | input | 1 | Request to invalidate every line |
| req_valid | input | 1 | Core request present |
| req_addr | input | 32 | Byte address of the requested word |
| req_is_data | input | 1 | 1 for an operand read, 0 for an instruction fetch |
| req_stall | output | 1 | Block is not taking requests this cycle |
| rsp_valid | output | 1 | Response word valid |
| rsp_data | output | 32 | Response word |
| mem_req_valid | output | 1 | Line fetch request to memory |
| mem_req_addr | output | 32 | Line-aligned fetch address |
| mem_req_ready | input | 1 | Memory takes the fetch request |
| mem_beat_valid | input | 1 | Returned beat present |
| mem_beat_data | input | 32 | Returned beat data |

## Verification
Some properties are checked by assertions on every cycle. These are the memory request protocol: the fetch address is line-aligned and stays stable until accepted, and a fetch is only outstanding while requests are stalled. The assertions also check that a mode change or an invalidate stalls the next cycle, and that a response outside a fill always answers a presented request. Other behaviour only the bench scenarios can show. That covers the index formation in each mode, the separation of the two halves in split mode, conflict eviction, bypass without allocation, the cycle of the requested beat, the exact 129-cycle clear and the loss of every line after it. The bench shows these through full sweeps of the store, with memory words computed from their addresses.

// File: rtl/cache_pkg.sv
package cache_pkg;

    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int LINES    = 128;
    localparam int WORDS    = 4;

    localparam int LINE_W   = $clog2(LINES);
    localparam int OFF_W    = $clog2(WORDS);
    localparam int BYTE_W   = $clog2(DATA_W / 8);
    localparam int WIDX_W   = LINE_W + OFF_W;
    localparam int HALF_W   = LINE_W - 1;
    localparam int LBASE    = BYTE_W + OFF_W;
    localparam int TAG_LSB  = LBASE + HALF_W;
    localparam int TAG_W    = ADDR_W - TAG_LSB;
    localparam int LADDR_W  = ADDR_W - LBASE;

    typedef enum logic [1:0] {
        MODE_INSN      = 2'b00,
        MODE_DATA      = 2'b01,
        MODE_SPLIT     = 2'b10,
        MODE_SPLIT_ALT = 2'b11
    } cache_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_FILL,
        ST_WRITE,
        ST_CLEAR
    } ctrl_state_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [LINE_W-1:0] line;
        logic [OFF_W-1:0]  word;
        logic              bypass;
    } lookup_t;

    typedef struct packed {
        logic [LADDR_W-1:0] line_addr;
        logic [LINE_W-1:0]  line;
        logic [OFF_W-1:0]   word;
        logic [TAG_W-1:0]   tag;
        logic               alloc;
    } miss_t;

    function automatic logic mode_is_split(cache_mode_e m);
        return m[1];
    endfunction

    function automatic logic [LINE_W-1:0] form_line(cache_mode_e m,
                                                    logic [ADDR_W-1:0] a,
                                                    logic is_data);
        if (mode_is_split(m))
            return {is_data, a[LBASE +: HALF_W]};
        return a[LBASE +: LINE_W];
    endfunction

    function automatic logic skip_type(cache_mode_e m, logic is_data);
        return (m == MODE_INSN && is_data) || (m == MODE_DATA && !is_data);
    endfunction

endpackage

// File: rtl/cache_index.sv
module cache_index
    import cache_pkg::*;
(
    input  cache_mode_e       mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_data,
    output lookup_t           lk
);
    always_comb begin
        lk.tag    = addr[ADDR_W-1:TAG_LSB];
        lk.line   = form_line(mode, addr, is_data);
        lk.word   = addr[BYTE_W +: OFF_W];
        lk.bypass = skip_type(mode, is_data);
    end
endmodule

// File: rtl/cache_store.sv
module cache_store
    import cache_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [LINE_W-1:0]             rd_line,
    input  logic [OFF_W-1:0]              rd_word,
    output logic                          rd_valid,
    output logic [TAG_W-1:0]              rd_tag,
    output logic [DATA_W-1:0]             rd_data,
    input  logic                          wr_en,
    input  logic [LINE_W-1:0]             wr_line,
    input  logic [TAG_W-1:0]              wr_tag,
    input  logic [WORDS-1:0][DATA_W-1:0]  wr_words,
    input  logic                          clr_en,
    input  logic [LINE_W-1:0]             clr_line
);
    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES*WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (clr_en) begin
            valid_q[clr_line] <= 1'b0;
        end else if (wr_en) begin
            valid_q[wr_line] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_line] <= wr_tag;
            for (int k = 0; k < WORDS; k++) begin
                data_q[{wr_line, OFF_W'(k)}] <= wr_words[k];
            end
        end
    end

    always_comb begin
        rd_valid = valid_q[rd_line];
        rd_tag   = tag_q[rd_line];
        rd_data  = data_q[{rd_line, rd_word}];
    end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [1:0]                    cfg_mode,
    input  logic                          inval,
    input  logic                          start_miss,
    input  miss_t                         miss_in,
    input  logic                          mem_req_ready,
    input  logic                          mem_beat_valid,
    input  logic [DATA_W-1:0]             mem_beat_data,
    output cache_mode_e                   mode_q,
    output logic                          busy,
    output logic                          mem_req_valid,
    output logic [ADDR_W-1:0]             mem_req_addr,
    output logic                          fill_rsp_valid,
    output logic [DATA_W-1:0]             fill_rsp_data,
    output logic                          wr_en,
    output logic [LINE_W-1:0]             wr_line,
    output logic [TAG_W-1:0]              wr_tag,
    output logic [WORDS-1:0][DATA_W-1:0]  wr_words,
    output logic                          clr_en,
    output logic [LINE_W-1:0]             clr_line
);
    ctrl_state_e                 state_q;
    logic                        pend_q;
    logic [OFF_W-1:0]            beat_q;
    logic [LINE_W-1:0]           clr_q;
    miss_t                       mq;
    logic [WORDS-1:0][DATA_W-1:0] fill_buf;
    logic                        trigger;

    assign trigger = inval || (cfg_mode != mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= cache_mode_e'(cfg_mode);
            pend_q  <= 1'b0;
            beat_q  <= '0;
            clr_q   <= '0;
            mq      <= '0;
        end else begin
            mode_q <= cache_mode_e'(cfg_mode);
            case (state_q)
                ST_IDLE: begin
                    if (pend_q) begin
                        state_q <= ST_CLEAR;
                        clr_q   <= '0;
                        pend_q  <= 1'b0;
                    end else if (start_miss) begin
                        mq      <= miss_in;
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) begin
                        state_q <= ST_FILL;
                        beat_q  <= '0;
                    end
                end
                ST_FILL: begin
                    if (mem_beat_valid) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == OFF_W'(WORDS - 1))
                            state_q <= mq.alloc ? ST_WRITE : ST_IDLE;
                    end
                end
                ST_WRITE: state_q <= ST_IDLE;
                ST_CLEAR: begin
                    clr_q <= clr_q + 1'b1;
                    if (clr_q == LINE_W'(LINES - 1))
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
            if (trigger)
                pend_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (state_q == ST_FILL && mem_beat_valid)
            fill_buf[beat_q] <= mem_beat_data;
    end

    always_comb begin
        busy           = (state_q != ST_IDLE) || pend_q;
        mem_req_valid  = (state_q == ST_REQ);
        mem_req_addr   = {mq.line_addr, {LBASE{1'b0}}};
        fill_rsp_valid = (state_q == ST_FILL) && mem_beat_valid && (beat_q == mq.word);
        fill_rsp_data  = mem_beat_data;
        wr_en          = (state_q == ST_WRITE);
        wr_line        = mq.line;
        wr_tag         = mq.tag;
        wr_words       = fill_buf;
        clr_en         = (state_q == ST_CLEAR);
        clr_line       = clr_q;
    end
endmodule

// File: rtl/cfg_split_cache.sv
module cfg_split_cache
    import cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic              inval,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_data,
    output logic              req_stall,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_beat_valid,
    input  logic [DATA_W-1:0] mem_beat_data
);
    cache_mode_e                  mode_q;
    lookup_t                      lk;
    miss_t                        miss_in;
    logic                         busy;
    logic                         rd_valid;
    logic [TAG_W-1:0]             rd_tag;
    logic [DATA_W-1:0]            rd_data;
    logic                         hit, accept, hit_rsp, start_miss;
    logic                         fill_rsp_valid;
    logic [DATA_W-1:0]            fill_rsp_data;
    logic                         wr_en, clr_en;
    logic [LINE_W-1:0]            wr_line, clr_line;
    logic [TAG_W-1:0]             wr_tag;
    logic [WORDS-1:0][DATA_W-1:0] wr_words;

    cache_index u_index (
        .mode    (mode_q),
        .addr    (req_addr),
        .is_data (req_is_data),
        .lk      (lk)
    );

    cache_store u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_line  (lk.line),
        .rd_word  (lk.word),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_line  (wr_line),
        .wr_tag   (wr_tag),
        .wr_words (wr_words),
        .clr_en   (clr_en),
        .clr_line (clr_line)
    );

    always_comb begin
        hit        = rd_valid && (rd_tag == lk.tag) && !lk.bypass;
        accept     = req_valid && !busy;
        hit_rsp    = accept && hit;
        start_miss = accept && !hit;
        miss_in.line_addr = req_addr[ADDR_W-1:LBASE];
        miss_in.line      = lk.line;
        miss_in.word      = lk.word;
        miss_in.tag       = lk.tag;
        miss_in.alloc     = !lk.bypass;
    end

    cache_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .cfg_mode       (cfg_mode),
        .inval          (inval),
        .start_miss     (start_miss),
        .miss_in        (miss_in),
        .mem_req_ready  (mem_req_ready),
        .mem_beat_valid (mem_beat_valid),
        .mem_beat_data  (mem_beat_data),
        .mode_q         (mode_q),
        .busy           (busy),
        .mem_req_valid  (mem_req_valid),
        .mem_req_addr   (mem_req_addr),
        .fill_rsp_valid (fill_rsp_valid),
        .fill_rsp_data  (fill_rsp_data),
        .wr_en          (wr_en),
        .wr_line        (wr_line),
        .wr_tag         (wr_tag),
        .wr_words       (wr_words),
        .clr_en         (clr_en),
        .clr_line       (clr_line)
    );

    always_comb begin
        req_stall = busy;
        rsp_valid = hit_rsp || fill_rsp_valid;
        rsp_data  = hit_rsp ? rd_data : fill_rsp_data;
    end
endmodule

// File: rtl/cfg_split_cache_checker.sv
module cfg_split_cache_checker (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  cfg_mode,
    input logic        inval,
    input logic        req_valid,
    input logic        req_stall,
    input logic        rsp_valid,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr
);
    // R6: fetch request held with a stable address until accepted
    a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R6: fetch address is line-aligned
    a_r6_line_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[3:0] == 4'd0));

    // R12: a fetch is outstanding only while requests are stalled
    a_r12_fetch_stalls: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> req_stall);

    // R2: a response outside a fill answers a presented request
    a_r2_rsp_has_req: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !req_stall) |-> req_valid);

    // R10: a mode change stalls the following cycle
    a_r10_mode_stall: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode != $past(cfg_mode)) |=> req_stall);

    // R10: an invalidate stalls the following cycle
    a_r10_inval_stall: assert property (@(posedge clk) disable iff (rst)
        inval |=> req_stall);
endmodule

bind cfg_split_cache cfg_split_cache_checker i_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_mode      (cfg_mode),
    .inval         (inval),
    .req_valid     (req_valid),
    .req_stall     (req_stall),
    .rsp_valid     (rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/test_cfg_split_cache.sv
module test_cfg_split_cache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_mode = 2'b00;
    logic        inval = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_is_data = 1'b0;
    logic        req_stall, rsp_valid, mem_req_valid;
    logic [31:0] rsp_data, mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_beat_valid = 1'b0;
    logic [31:0] mem_beat_data = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cfg_split_cache i_cfg_split_cache (
        .clk            (clk),
        .rst            (rst),
        .cfg_mode       (cfg_mode),
        .inval          (inval),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_is_data    (req_is_data),
        .req_stall      (req_stall),
        .rsp_valid      (rsp_valid),
        .rsp_data       (rsp_data),
        .mem_req_valid  (mem_req_valid),
        .mem_req_addr   (mem_req_addr),
        .mem_req_ready  (mem_req_ready),
        .mem_beat_valid (mem_beat_valid),
        .mem_beat_data  (mem_beat_data)
    );

    function automatic logic [31:0] memw(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // One core access; plays the memory on a miss.
    task automatic access(input logic [31:0] a, input logic d, input bit exp_hit,
                          input bit exp_alloc, input string req);
        int guard;
        logic [31:0] base;
        base = {a[31:4], 4'b0};
        @(negedge clk);
        req_addr = a; req_is_data = d; req_valid = 1'b1;
        #5;
        guard = 0;
        while (req_stall && guard < 1000) begin
            @(negedge clk); #5; guard++;
        end
        if (rsp_valid) begin
            chk(exp_hit, {req, " unexpected hit"}, 32'd1, 32'd0);
            chk(rsp_data == memw(a), {req, " R2 hit data"}, rsp_data, memw(a));
            @(negedge clk);
            req_valid = 1'b0;
        end else begin
            chk(!exp_hit, {req, " R2 expected hit"}, 32'd0, 32'd1);
            @(negedge clk);
            req_valid = 1'b0;
            #5;
            chk(mem_req_valid && mem_req_addr == base, {req, " R6 fetch addr"}, mem_req_addr, base);
            @(negedge clk); #5;
            chk(mem_req_valid && mem_req_addr == base, {req, " R6 fetch held"}, mem_req_addr, base);
            @(negedge clk);
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            for (int k = 0; k < 4; k++) begin
                logic [31:0] wa;
                wa = {a[31:4], 2'(k), 2'b00};
                mem_beat_valid = 1'b1;
                mem_beat_data  = memw(wa);
                #5;
                if (k == int'(a[3:2]))
                    chk(rsp_valid && rsp_data == memw(a), {req, " R7 word on its beat"}, rsp_data, memw(a));
                else
                    chk(!rsp_valid, {req, " R7 no rsp on other beat"}, {31'd0, rsp_valid}, 32'd0);
                @(negedge clk);
            end
            mem_beat_valid = 1'b0;
            #5;
            chk(req_stall == exp_alloc, {req, " R8 write cycle"}, {31'd0, req_stall}, {31'd0, exp_alloc});
        end
    endtask

    // Caller raised the trigger at the previous negedge.
    task automatic count_stall(input string req);
        int n;
        bit bad;
        n = 0; bad = 0;
        @(negedge clk);
        inval = 1'b0;
        req_addr = 32'h0000_0040; req_is_data = 1'b0; req_valid = 1'b1;
        #5;
        while (req_stall && n < 1000) begin
            n++;
            if (rsp_valid || mem_req_valid) bad = 1;
            @(negedge clk); #5;
        end
        req_valid = 1'b0;
        chk(n == 129, {req, " R10 stall length"}, n, 129);
        chk(!bad, {req, " R12 request ignored during clear"}, {31'd0, bad}, 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        chk(!req_stall, "R11 stall after reset", {31'd0, req_stall}, 32'd0);
        chk(!rsp_valid, "R11 rsp after reset", {31'd0, rsp_valid}, 32'd0);
        chk(!mem_req_valid, "R11 fetch after reset", {31'd0, mem_req_valid}, 32'd0);

        // R3/R11: instruction-only, fill all 128 lines, then every word hits
        for (int ln = 0; ln < 128; ln++)
            access(ln * 16 + (ln % 4) * 4, 1'b0, 1'b0, 1'b1, "R3 fill");
        for (int w = 0; w < 512; w++)
            access(w * 4, 1'b0, 1'b1, 1'b1, "R3 sweep");

        // R5: tag conflict 2 Kbytes apart
        access(32'h0000_0850, 1'b0, 1'b0, 1'b1, "R5 evict");
        access(32'h0000_0050, 1'b0, 1'b0, 1'b1, "R5 refetch");
        access(32'h0000_0050, 1'b0, 1'b1, 1'b1, "R5 resident");

        // R9: operand reads bypass in instruction-only mode
        access(32'h0001_0058, 1'b1, 1'b0, 1'b0, "R9 bypass");
        access(32'h0001_0058, 1'b1, 1'b0, 1'b0, "R9 bypass again");
        access(32'h0000_0050, 1'b1, 1'b0, 1'b0, "R9 bypass same addr");
        access(32'h0000_0050, 1'b0, 1'b1, 1'b1, "R9 line untouched");

        // R10: mode change to split clears
        @(negedge clk); cfg_mode = 2'b10;
        count_stall("split");
        access(32'h0000_0050, 1'b0, 1'b0, 1'b1, "R10 cleared");

        // R4: split halves
        for (int ln = 0; ln < 64; ln++)
            access(ln * 16 + (ln % 4) * 4, 1'b0, ln == 5, 1'b1, "R4 insn fill");
        for (int ln = 0; ln < 64; ln++)
            access(32'h4000 + ln * 16 + ((ln + 1) % 4) * 4, 1'b1, 1'b0, 1'b1, "R4 data fill");
        for (int w = 0; w < 256; w++) begin
            access(w * 4, 1'b0, 1'b1, 1'b1, "R4 insn sweep");
            access(32'h4000 + w * 4, 1'b1, 1'b1, 1'b1, "R4 data sweep");
        end
        access(32'h0000_0450, 1'b0, 1'b0, 1'b1, "R4 1K conflict");
        access(32'h0000_0050, 1'b0, 1'b0, 1'b1, "R4 1K refetch");
        access(32'h0000_4050, 1'b1, 1'b1, 1'b1, "R4 other half kept");

        // R10: invalidate input
        @(negedge clk); inval = 1'b1;
        count_stall("inval");
        access(32'h0000_4050, 1'b1, 1'b0, 1'b1, "R10 inval cleared");

        // R1/R3/R9: operand-only mode
        @(negedge clk); cfg_mode = 2'b01;
        count_stall("data-only");
        access(32'h0000_0100, 1'b1, 1'b0, 1'b1, "R1 data miss");
        access(32'h0000_0100, 1'b1, 1'b1, 1'b1, "R1 data hit");
        access(32'h0000_0500, 1'b1, 1'b0, 1'b1, "R3 bit10 index");
        access(32'h0000_0100, 1'b1, 1'b1, 1'b1, "R3 no 1K conflict");
        access(32'h0000_0100, 1'b0, 1'b0, 1'b0, "R9 insn bypass");
        access(32'h0000_0100, 1'b0, 1'b0, 1'b0, "R9 insn bypass again");

        // R1: code 2'b11 is split
        @(negedge clk); cfg_mode = 2'b11;
        count_stall("split-alt");
        access(32'h0000_0050, 1'b0, 1'b0, 1'b1, "R1 alt insn miss");
        access(32'h0000_0050, 1'b1, 1'b0, 1'b1, "R1 alt data miss");
        access(32'h0000_0050, 1'b0, 1'b1, 1'b1, "R1 alt insn hit");
        access(32'h0000_0050, 1'b1, 1'b1, 1'b1, "R1 alt data hit");

        // R12: stray beats outside a fill
        @(negedge clk);
        mem_beat_valid = 1'b1; mem_beat_data = 32'hDEAD_BEEF;
        #5;
        chk(!rsp_valid, "R12 stray beat no rsp", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
        mem_beat_valid = 1'b0;
        access(32'h0000_0050, 1'b0, 1'b1, 1'b1, "R12 line intact");

        report();
        $finish;
    end
endmodule